// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is a watchdog that asks for a system reset when software stops servicing it. Software controls it through four word-wide registers on a simple write port and a combinational read port. The registers are a key register, a down-counting timer, a control register and a status register. The timer and control registers are guarded. A write to either has no effect until the exact unlock value has been written to the key register. Writing any other value to the key register locks them again.

When counting is enabled, the timer falls by one every clock until it reaches zero. If it sits at zero while counting is enabled, the block treats that as expiry. With reset enabled, expiry starts a reset request pulse of fixed length. At the end of the pulse every register returns to its reset value, so the block comes back disabled and locked. With the flag enable set, expiry also raises a sticky status flag, which software clears by writing a one.

A timer loaded with zero followed by enabling counting and reset gives an immediate reset request. Software uses this as a deliberate way to restart the system.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, rst_req and expired are 0 and all four registers read 0 (the key register reads its lock state in bit 0: 1 = unlocked).
- R2: Writing the full data word 0x0000_482E to register address 0 unlocks the guarded registers, and address 0 then reads 1.
- R3: Writing any other word to address 0 locks the guarded registers, and address 0 then reads 0. This includes words whose low 16 bits equal 0x482E.
- R4: While locked, writes to the timer (address 1) and control (address 2) registers are ignored, and both read back unchanged.
- R5: The control register at address 2 holds three bits: bit 0 reset enable, bit 1 count enable and bit 2 flag enable. Higher written bits are dropped and read as 0.
- R6: While count enable is set, a nonzero timer drops by exactly one per clock and stays at 0 once there. With count enable clear, the timer holds its value.
- R7: When the timer is 0 with count and reset enabled, rst_req is high in the next cycle. A timer loaded with T asserts rst_req T+1 cycles after the control write takes effect, and T = 0 gives the request immediately.
- R8: rst_req stays high for exactly PULSE_LEN (default 4) consecutive cycles per expiry.
- R9: In the cycle after rst_req falls, timer, control and status read 0 and the guarded registers are locked.
- R10: Expiry with flag enable set raises expired (status address 3, bit 0) in the next cycle. The flag stays set without causing a reset when reset enable is clear. Writing 1 to bit 0 of address 3 clears it, and writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | DATA_W | Read data (combinational) |
| rst_req | output | 1 | System reset request pulse |
| expired | output | 1 | Sticky expiry flag |

## Verification
A lock bit left set by mistake shows up at the key readback within one cycle of the write that should have cleared it. It also shows up as a guarded write that takes effect when it should not. A timer that steps wrongly moves the rising edge of rst_req away from cycle T+1, and the timer readback differs at every sample in between. A pulse counter or restore path that is off by one shows up as a pulse one cycle too short or too long, or as registers that are still nonzero in the cycle after rst_req falls. Sweeping every timer value from 0 to 7 against all eight control codes makes each of these faults visible within a few cycles of the control write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    SEL_KEY    = 2'd0,
    SEL_TIMER  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } wdg_sel_e;

  typedef struct packed {
    logic flag_en;   // bit 2
    logic count_en;  // bit 1
    logic reset_en;  // bit 0
  } wdg_ctrl_t;

  localparam int CTRL_W = $bits(wdg_ctrl_t);
endpackage

// File: rtl/wdg_keygate.sv
module wdg_keygate #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] KEY_VALUE = 32'h0000_482E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              restore,
  output logic              unlocked
);
  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY_VALUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unlocked <= 1'b0;
    else if (restore) unlocked <= 1'b0;
    else if (key_wr)  unlocked <= (key_data == KEY_W);
  end

  AST_BAD_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != KEY_W) |=> !unlocked); // R3
  AST_UNLOCK_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr)); // R2
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restore,
  input  logic             tmr_wr,
  input  logic             ctrl_wr,
  input  logic [TMR_W-1:0] tmr_data,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic             flag_clr,
  output logic [TMR_W-1:0] timer,
  output wdg_ctrl_t        ctrl,
  output logic             flag,
  output logic             expire
);
  assign expire = ctrl.count_en && (timer == '0) && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      ctrl  <= '0;
    end else if (restore) begin
      timer <= '0;
      ctrl  <= '0;
    end else if (!hold) begin
      if (tmr_wr)                              timer <= tmr_data;
      else if (ctrl.count_en && timer != '0)   timer <= timer - 1'b1;
      if (ctrl_wr) ctrl <= wdg_ctrl_t'(ctrl_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         flag <= 1'b0;
    else if (restore)                   flag <= 1'b0;
    else if (expire && ctrl.flag_en)    flag <= 1'b1;
    else if (flag_clr)                  flag <= 1'b0;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.count_en && timer != '0 && !hold && !restore && !tmr_wr)
      |=> timer == $past(timer) - 1'b1); // R6
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (timer == '0 && !tmr_wr) |=> timer == '0); // R6
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.count_en && !tmr_wr && !restore) |=> $stable(timer)); // R6
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse,
  output logic restore
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam int RW = $clog2(PULSE_LEN + 2);

  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  left <= '0;
    else if (left != '0)         left <= left - 1'b1;
    else if (fire)               left <= CW'(PULSE_LEN);
  end

  assign pulse   = (left != '0);
  assign restore = (left == CW'(1));

  // run-length observer for the pulse width check
  logic [RW-1:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run <= '0;
    else if (!pulse)                     run <= '0;
    else if (run != RW'(PULSE_LEN + 1))  run <= run + 1'b1;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> run == RW'(PULSE_LEN)); // R8
  AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pulse) |=> pulse); // R7
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          TMR_W     = 32,
  parameter int          PULSE_LEN = 4,
  parameter logic [31:0] KEY_VALUE = 32'h0000_482E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req,
  output logic              expired
);
  logic             unlocked, restore, expire, wr_ok;
  logic [TMR_W-1:0] timer;
  wdg_ctrl_t        ctrl;

  assign wr_ok = wr_en && !rst_req;

  wdg_keygate #(.DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)) u_key (
    .clk(clk), .rst_n(rst_n),
    .key_wr(wr_ok && wdg_sel_e'(wr_addr) == SEL_KEY),
    .key_data(wr_data), .restore(restore), .unlocked(unlocked));

  wdg_counter #(.TMR_W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(rst_req), .restore(restore),
    .tmr_wr(wr_ok && unlocked && wdg_sel_e'(wr_addr) == SEL_TIMER),
    .ctrl_wr(wr_ok && unlocked && wdg_sel_e'(wr_addr) == SEL_CTRL),
    .tmr_data(wr_data[TMR_W-1:0]), .ctrl_data(wr_data[CTRL_W-1:0]),
    .flag_clr(wr_ok && wdg_sel_e'(wr_addr) == SEL_STATUS && wr_data[0]),
    .timer(timer), .ctrl(ctrl), .flag(expired), .expire(expire));

  wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire && ctrl.reset_en),
    .pulse(rst_req), .restore(restore));

  always_comb begin
    unique case (wdg_sel_e'(rd_addr))
      SEL_KEY:    rd_data = {{(DATA_W-1){1'b0}}, unlocked};
      SEL_TIMER:  rd_data = DATA_W'(timer);
      SEL_CTRL:   rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      default:    rd_data = {{(DATA_W-1){1'b0}}, expired};
    endcase
  end

  AST_LOCKED_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !ctrl.count_en && !rst_req) |=> ($stable(timer) && $stable(ctrl))); // R4
  AST_RESTORED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (!unlocked && timer == '0 && ctrl == '0 && !expired)); // R9
  AST_ZERO_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (timer == '0 && ctrl.count_en && ctrl.reset_en && !rst_req) |=> rst_req); // R7
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl.flag_en) |=> expired); // R10
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  localparam int PL = 4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rst_req, expired;
  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  keyed_watchdog uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .expired(expired));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg readback", v, 32'd0);
    end
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
    chk("R1 expired", {31'd0, expired}, 32'd0);
    // R4: locked writes ignored
    wr(2'd1, 32'd5); wr(2'd2, 32'd3);
    rd(2'd1, v); chk("R4 locked timer", v, 32'd0);
    rd(2'd2, v); chk("R4 locked ctrl", v, 32'd0);
    // R2: unlock
    wr(2'd0, 32'h0000_482E);
    rd(2'd0, v); chk("R2 unlocked", v, 32'd1);
    wr(2'd1, 32'd9);
    rd(2'd1, v); chk("R2 timer write accepted", v, 32'd9);
    // R5: upper control bits dropped
    wr(2'd2, 32'hFFFF_FFF8);
    rd(2'd2, v); chk("R5 upper bits dropped", v, 32'd0);
    wr(2'd2, 32'hFFFF_FFF9);
    rd(2'd2, v); chk("R5 reset enable only", v, 32'd1);
    rd(2'd1, v); chk("R6 timer holds without count", v, 32'd9);
    // R3: wrong key relocks, including matching low half
    wr(2'd0, 32'h0001_482E);
    rd(2'd0, v); chk("R3 relock high bits", v, 32'd0);
    wr(2'd1, 32'd3);
    rd(2'd1, v); chk("R3 write after relock ignored", v, 32'd9);
    wr(2'd0, 32'h0000_482E);
    wr(2'd0, 32'h0000_482F);
    rd(2'd0, v); chk("R3 relock near key", v, 32'd0);
    wr(2'd2, 32'd0);
    rd(2'd2, v); chk("R4 ctrl unchanged", v, 32'd1);

    // R10: flag without reset, clear semantics
    do_reset();
    wr(2'd0, 32'h0000_482E); wr(2'd1, 32'd2); wr(2'd2, 32'd6);
    repeat (4) @(negedge clk);
    chk("R10 flag set", {31'd0, expired}, 32'd1);
    chk("R10 no reset", {31'd0, rst_req}, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd3, 32'd0);
    chk("R10 write 0 keeps flag", {31'd0, expired}, 32'd1);
    wr(2'd3, 32'd1);
    chk("R10 write 1 clears flag", {31'd0, expired}, 32'd0);
    rd(2'd3, v); chk("R10 status readback", v, 32'd0);

    // Sweep: timer 0..7 x control 0..7 (R6, R7, R8, R9, R10)
    for (int t = 0; t < 8; t++) begin
      for (int e = 0; e < 8; e++) begin
        bit cen, ren, fen, pulse, restored;
        int exp_t;
        do_reset();
        wr(2'd0, 32'h0000_482E);
        wr(2'd1, 32'(t));
        wr(2'd2, 32'(e));
        cen = e[1]; ren = e[0]; fen = e[2];
        pulse = cen && ren;
        for (int k = 0; k <= t + PL + 3; k++) begin
          restored = pulse && (k >= t + PL + 1);
          exp_t = cen ? ((k >= t) ? 0 : t - k) : t;
          rd(2'd1, v); chk("R6 timer value", v, 32'(exp_t));
          chk("R7 R8 rst_req",
              {31'd0, rst_req},
              {31'd0, pulse && (k >= t + 1) && (k <= t + PL)});
          chk("R10 expired",
              {31'd0, expired},
              {31'd0, fen && cen && (k >= t + 1) && !restored});
          if (k == t + PL + 3) begin
            rd(2'd2, v); chk("R9 ctrl after run", v, restored ? 32'd0 : 32'(e));
            rd(2'd0, v); chk("R9 lock after run", v, restored ? 32'd0 : 32'd1);
          end
          @(negedge clk);
        end
      end
    end
    summary();
  end
endmodule